// File: doc/BRIEF.md
# Banked Host Register Window

This block decodes a 16-byte host register window. What each byte offset means depends on a stored bank number, and there are four banks. The window holds the transmit-control, receive-control, configuration, general-purpose, control, pointer and early-receive registers. Byte offset 14 selects the bank and is visible from every bank.

Status bytes from the packet allocator and the interrupt logic are not stored here. They arrive on plain input pins and are returned by reads. Host writes to the allocator's command, packet-number, data and interrupt bytes are stored for one cycle and presented on a forward strobe.

A host access is a byte, a 16-bit or a 32-bit access. The window splits it into little-endian byte accesses at a naturally aligned base, so byte lane k of the data maps to offset base+k. Every access is accepted in the cycle it is presented. There is no back-pressure, so the host may issue an access on every clock.

A host write of a receive-control high byte with bit 7 set requests a soft reset. That write raises a one-cycle reset pulse. At the end of the pulse every stored register returns to its reset value.

Top module: `bank_window`

## Requirements
- R1: After reset the outputs are: configuration 0xA0B1, control 0x1210, early receive 0x1F, transmit control 0, receive control 0, pointer 0, general purpose 0, bank 0, soft_rst 0.
- R2: Offset 14 writes and reads the bank number (low 2 bits) in every bank. Offset 15 always reads 0x33 and ignores writes.
- R3: Bank 0 layout. Offsets 0/1 hold transmit control (low/high byte). Offsets 4/5 hold receive control. Offset 3 reads 0x40. Offset 8 reads `pages_total` and offset 9 reads `pages_used`.
- R4: Bank 1 layout. Offsets 0/1 hold configuration, 10/11 hold general purpose and 12/13 hold control. A write to offset 12 stores the byte with bits 1:0 forced to 0.
- R5: Bank 3 layout. Offset 12 stores only the low 5 bits of the written byte as early receive. Offsets 8, 9, 10 and 11 read 0x30, 0x33, 0x91 and 0x33.
- R6: A write to bank 0 offset 5 with data bit 7 set stores the byte and raises soft_rst for exactly the next cycle. At the end of that cycle all stored registers take their R1 values, and any host write presented during that cycle is discarded.
- R7: The size code is 0 for a byte access, 1 for a 16-bit access and 2 for a 32-bit access. The base is the address with its low size bits cleared. Data byte k maps to offset base+k.
- R8: A 32-bit write whose base is 12 leaves offsets 12 and 13 untouched and writes only offsets 14 and 15.
- R9: A read returns its data on rd_data with rd_valid high in the cycle after it is presented. Lanes beyond the access size read 0. rd_valid is low after any cycle without a read.
- R10: Offsets with no register read 0 and ignore writes. This covers bank 0 offsets 2, 6, 7 and 10-13, bank 1 offsets 2-9, bank 2 offsets 0, 1 and 8-11, and bank 3 offsets 0-7 and 13.
- R11: Bank 2 layout. Offsets 6/7 hold the pointer, and a read of offset 7 clears bit 3 of the returned byte. Offsets 2, 3, 4, 5, 12 and 13 read `pkt_num`, `alloc_res`, `txdone_head`, `rx_head`, `irq_status` and `irq_mask`. Writes to offsets 0, 2 and 8-13 appear one cycle later on fwd_strb, fwd_addr and fwd_data. Pointer writes are not forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | Host access presented this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_size | input | 2 | 0 byte, 1 half, 2 word |
| acc_addr | input | 4 | Byte offset in the window |
| acc_wdata | input | 32 | Write data, lane k to offset base+k |
| pages_total | input | 8 | Page count status byte |
| pages_used | input | 8 | Pages in use status byte |
| pkt_num | input | 8 | Current packet number |
| alloc_res | input | 8 | Allocation result |
| txdone_head | input | 8 | Head of transmit-done queue |
| rx_head | input | 8 | Head of receive queue |
| irq_status | input | 8 | Interrupt status byte |
| irq_mask | input | 8 | Interrupt mask byte |
| rd_valid | output | 1 | rd_data is valid |
| rd_data | output | 32 | Read data |
| tx_ctrl | output | 16 | Transmit control register |
| rx_ctrl | output | 16 | Receive control register |
| cfg | output | 16 | Configuration register |
| gp | output | 16 | General purpose register |
| ctl | output | 16 | Control register |
| ptr | output | 16 | Pointer register |
| ercv | output | 5 | Early receive threshold |
| soft_rst | output | 1 | One-cycle soft reset pulse |
| fwd_strb | output | 4 | Per-lane forwarded write strobe |
| fwd_addr | output | 4 | Base offset of forwarded write |
| fwd_data | output | 32 | Forwarded write data |

## Verification
Timing from the clock edge that samples an access:

| Result | When it is visible |
|---|---|
| Register outputs and the forward strobe | just after that edge |
| Read data and rd_valid | just after that edge |
| soft_rst | high for the one cycle after the triggering write's edge |
| Reset values | after the following edge |

The bench drives each access half a cycle before its sampling edge and checks results on the falling edge that follows. This places each check in the first cycle the result is due. Back-to-back accesses are used to show that a write landing in the soft-reset cycle has no effect.

// File: rtl/bwin_pkg.sv
package bwin_pkg;
  localparam int AW     = 4;
  localparam int DW     = 32;
  localparam int LANES  = DW / 8;
  localparam int BANK_W = 2;
  localparam int RW     = 16;
  localparam int ERCV_W = 5;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  localparam logic [AW-1:0] OFF_BANK  = AW'(14);
  localparam logic [AW-1:0] OFF_ID    = AW'(15);
  localparam logic [AW-1:0] SKIP_BASE = AW'(12);

  localparam logic [7:0] ID_BYTE   = 8'h33;
  localparam logic [7:0] B0_FIXED3 = 8'h40;
  localparam logic [7:0] CTL_LO_KEEP = 8'hFC;
  localparam logic [7:0] PTR_HI_RD   = 8'hF7;

  typedef struct packed {
    logic [BANK_W-1:0] bank;
    logic [RW-1:0]     tx;
    logic [RW-1:0]     rx;
    logic [RW-1:0]     cfg;
    logic [RW-1:0]     gp;
    logic [RW-1:0]     ctl;
    logic [RW-1:0]     ptr;
    logic [ERCV_W-1:0] ercv;
  } regs_t;

  typedef struct packed {
    logic [7:0] pages_total;
    logic [7:0] pages_used;
    logic [7:0] pkt_num;
    logic [7:0] alloc_res;
    logic [7:0] txdone_head;
    logic [7:0] rx_head;
    logic [7:0] irq_status;
    logic [7:0] irq_mask;
  } stat_t;

  localparam regs_t REGS_RST = '{
    bank: '0, tx: '0, rx: '0, cfg: 16'hA0B1, gp: '0,
    ctl: 16'h1210, ptr: '0, ercv: 5'h1F};
endpackage

// File: rtl/bwin_lane_split.sv
module bwin_lane_split
  import bwin_pkg::*;
#(
  parameter int LN = LANES,
  parameter int A  = AW
) (
  input  logic [A-1:0]    addr,
  input  logic [1:0]      size,
  input  logic            wr,
  output logic [A-1:0]    base,
  output logic [LN-1:0]   lane_en,
  output logic [LN*A-1:0] lane_off
);
  logic [1:0] sz;
  int         span;

  always_comb begin
    sz   = (size > SZ_WORD) ? SZ_WORD : size;
    span = 1 << sz;
    base = addr & ~A'(span - 1);
    for (int k = 0; k < LN; k++) begin
      lane_off[k*A +: A] = base + A'(k);
      lane_en[k]         = (k < span);
      // a full-width write at the skip base touches only its upper half
      if (wr && sz == SZ_WORD && base == SKIP_BASE && k < LN / 2)
        lane_en[k] = 1'b0;
    end
  end
endmodule

// File: rtl/bwin_rdbyte.sv
module bwin_rdbyte
  import bwin_pkg::*;
(
  input  logic [AW-1:0] off,
  input  regs_t         r,
  input  stat_t         s,
  output logic [7:0]    val
);
  always_comb begin
    val = 8'h00;
    if (off == OFF_BANK) begin
      val = 8'(r.bank);
    end else if (off == OFF_ID) begin
      val = ID_BYTE;
    end else begin
      case (r.bank)
        2'd0: case (off)
          4'd0: val = r.tx[7:0];
          4'd1: val = r.tx[15:8];
          4'd3: val = B0_FIXED3;
          4'd4: val = r.rx[7:0];
          4'd5: val = r.rx[15:8];
          4'd8: val = s.pages_total;
          4'd9: val = s.pages_used;
          default: val = 8'h00;
        endcase
        2'd1: case (off)
          4'd0:  val = r.cfg[7:0];
          4'd1:  val = r.cfg[15:8];
          4'd10: val = r.gp[7:0];
          4'd11: val = r.gp[15:8];
          4'd12: val = r.ctl[7:0];
          4'd13: val = r.ctl[15:8];
          default: val = 8'h00;
        endcase
        2'd2: case (off)
          4'd2:  val = s.pkt_num;
          4'd3:  val = s.alloc_res;
          4'd4:  val = s.txdone_head;
          4'd5:  val = s.rx_head;
          4'd6:  val = r.ptr[7:0];
          4'd7:  val = r.ptr[15:8] & PTR_HI_RD;
          4'd12: val = s.irq_status;
          4'd13: val = s.irq_mask;
          default: val = 8'h00;
        endcase
        default: case (off)
          4'd8:  val = 8'h30;
          4'd9:  val = 8'h33;
          4'd10: val = 8'h91;
          4'd11: val = 8'h33;
          4'd12: val = 8'(r.ercv);
          default: val = 8'h00;
        endcase
      endcase
    end
  end
endmodule

// File: rtl/bwin_regs.sv
module bwin_regs
  import bwin_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LANES-1:0]  we,
  input  logic [LANES*AW-1:0] lane_off,
  input  logic [AW-1:0]     base,
  input  logic [DW-1:0]     wdata,
  output regs_t             r_q,
  output logic              pend_q,
  output logic [LANES-1:0]  fstrb_q,
  output logic [AW-1:0]     fbase_q,
  output logic [DW-1:0]     fdata_q
);
  regs_t            nx;
  logic             trig;
  logic [LANES-1:0] fstrb;
  logic [AW-1:0]    off;
  logic [7:0]       b;

  always_comb begin
    nx    = r_q;
    trig  = 1'b0;
    fstrb = '0;
    off   = '0;
    b     = '0;
    for (int k = 0; k < LANES; k++) begin
      if (we[k]) begin
        off = lane_off[k*AW +: AW];
        b   = wdata[k*8 +: 8];
        if (off == OFF_BANK) begin
          nx.bank = b[BANK_W-1:0];
        end else if (off != OFF_ID) begin
          case (r_q.bank)
            2'd0: case (off)
              4'd0: nx.tx[7:0]  = b;
              4'd1: nx.tx[15:8] = b;
              4'd4: nx.rx[7:0]  = b;
              4'd5: begin
                nx.rx[15:8] = b;
                if (b[7]) trig = 1'b1;
              end
              default: ;
            endcase
            2'd1: case (off)
              4'd0:  nx.cfg[7:0]  = b;
              4'd1:  nx.cfg[15:8] = b;
              4'd10: nx.gp[7:0]   = b;
              4'd11: nx.gp[15:8]  = b;
              4'd12: nx.ctl[7:0]  = b & CTL_LO_KEEP;
              4'd13: nx.ctl[15:8] = b;
              default: ;
            endcase
            2'd2: case (off)
              4'd6: nx.ptr[7:0]  = b;
              4'd7: nx.ptr[15:8] = b;
              4'd0, 4'd2, 4'd8, 4'd9, 4'd10, 4'd11, 4'd12, 4'd13:
                fstrb[k] = 1'b1;
              default: ;
            endcase
            default: case (off)
              4'd12: nx.ercv = b[ERCV_W-1:0];
              default: ;
            endcase
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_q     <= REGS_RST;
      pend_q  <= 1'b0;
      fstrb_q <= '0;
      fbase_q <= '0;
      fdata_q <= '0;
    end else if (pend_q) begin
      r_q     <= REGS_RST;
      pend_q  <= 1'b0;
      fstrb_q <= '0;
    end else begin
      r_q     <= nx;
      pend_q  <= trig;
      fstrb_q <= fstrb;
      fbase_q <= base;
      fdata_q <= wdata;
    end
  end
endmodule

// File: rtl/bank_window.sv
module bank_window
  import bwin_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                acc_en,
  input  logic                acc_wr,
  input  logic [1:0]          acc_size,
  input  logic [AW-1:0]       acc_addr,
  input  logic [DW-1:0]       acc_wdata,
  input  logic [7:0]          pages_total,
  input  logic [7:0]          pages_used,
  input  logic [7:0]          pkt_num,
  input  logic [7:0]          alloc_res,
  input  logic [7:0]          txdone_head,
  input  logic [7:0]          rx_head,
  input  logic [7:0]          irq_status,
  input  logic [7:0]          irq_mask,
  output logic                rd_valid,
  output logic [DW-1:0]       rd_data,
  output logic [RW-1:0]       tx_ctrl,
  output logic [RW-1:0]       rx_ctrl,
  output logic [RW-1:0]       cfg,
  output logic [RW-1:0]       gp,
  output logic [RW-1:0]       ctl,
  output logic [RW-1:0]       ptr,
  output logic [ERCV_W-1:0]   ercv,
  output logic                soft_rst,
  output logic [LANES-1:0]    fwd_strb,
  output logic [AW-1:0]       fwd_addr,
  output logic [DW-1:0]       fwd_data
);
  logic [AW-1:0]       base;
  logic [LANES-1:0]    lane_en;
  logic [LANES*AW-1:0] lane_off;
  logic [LANES-1:0]    we;
  regs_t               r_q;
  stat_t               st;
  logic [DW-1:0]       rd_word;
  logic [DW-1:0]       rd_q;
  logic                rv_q;

  assign st = '{pages_total: pages_total, pages_used: pages_used,
                pkt_num: pkt_num, alloc_res: alloc_res,
                txdone_head: txdone_head, rx_head: rx_head,
                irq_status: irq_status, irq_mask: irq_mask};

  bwin_lane_split u_split (
    .addr(acc_addr), .size(acc_size), .wr(acc_wr),
    .base(base), .lane_en(lane_en), .lane_off(lane_off)
  );

  assign we = lane_en & {LANES{acc_en & acc_wr}};

  bwin_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we(we), .lane_off(lane_off), .base(base),
    .wdata(acc_wdata), .r_q(r_q), .pend_q(soft_rst),
    .fstrb_q(fwd_strb), .fbase_q(fwd_addr), .fdata_q(fwd_data)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_rd
    logic [7:0] byte_v;
    bwin_rdbyte u_rd (
      .off(lane_off[k*AW +: AW]), .r(r_q), .s(st), .val(byte_v)
    );
    assign rd_word[k*8 +: 8] = lane_en[k] ? byte_v : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rv_q <= 1'b0;
      rd_q <= '0;
    end else begin
      rv_q <= acc_en & ~acc_wr;
      if (acc_en && !acc_wr) rd_q <= rd_word;
    end
  end

  assign rd_valid = rv_q;
  assign rd_data  = rd_q;
  assign tx_ctrl  = r_q.tx;
  assign rx_ctrl  = r_q.rx;
  assign cfg      = r_q.cfg;
  assign gp       = r_q.gp;
  assign ctl      = r_q.ctl;
  assign ptr      = r_q.ptr;
  assign ercv     = r_q.ercv;
endmodule

// File: rtl/bwin_checker.sv
module bwin_checker
  import bwin_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              acc_en,
  input logic              acc_wr,
  input logic              rd_valid,
  input logic [RW-1:0]     tx_ctrl,
  input logic [RW-1:0]     rx_ctrl,
  input logic [RW-1:0]     cfg,
  input logic [RW-1:0]     gp,
  input logic [RW-1:0]     ctl,
  input logic [RW-1:0]     ptr,
  input logic [ERCV_W-1:0] ercv,
  input logic              soft_rst,
  input logic [LANES-1:0]  fwd_strb
);
  assert_rst_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !soft_rst);

  assert_rst_values_R1: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (cfg == 16'hA0B1 && ctl == 16'h1210 && ercv == 5'h1F &&
                  tx_ctrl == '0 && rx_ctrl == '0 && ptr == '0 && gp == '0));

  assert_ctl_low_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ctl[1:0] == 2'b00);

  assert_rd_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_wr) |=> rd_valid);

  assert_rd_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_en && !acc_wr) |=> !rd_valid);

  assert_idle_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_en && !soft_rst) |=> ($stable(cfg) && $stable(tx_ctrl) &&
      $stable(rx_ctrl) && $stable(ctl) && $stable(gp) && $stable(ptr)));

  assert_fwd_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_en && acc_wr) |=> fwd_strb == '0);
endmodule

bind bank_window bwin_checker u_chk (
  .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
  .rd_valid(rd_valid), .tx_ctrl(tx_ctrl), .rx_ctrl(rx_ctrl), .cfg(cfg),
  .gp(gp), .ctl(ctl), .ptr(ptr), .ercv(ercv), .soft_rst(soft_rst),
  .fwd_strb(fwd_strb)
);

// File: tb/sim_bank_window.sv
`timescale 1ns/1ps
module sim_bank_window;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_en = 1'b0, acc_wr = 1'b0;
  logic [1:0]  acc_size = 2'd0;
  logic [3:0]  acc_addr = 4'd0;
  logic [31:0] acc_wdata = 32'd0;
  logic [7:0]  pages_total = 8'd4, pages_used = 8'd2, pkt_num = 8'h03;
  logic [7:0]  alloc_res = 8'h80, txdone_head = 8'h11, rx_head = 8'h22;
  logic [7:0]  irq_status = 8'h44, irq_mask = 8'h55;
  logic        rd_valid, soft_rst;
  logic [31:0] rd_data, fwd_data;
  logic [15:0] tx_ctrl, rx_ctrl, cfg, gp, ctl, ptr;
  logic [4:0]  ercv;
  logic [3:0]  fwd_strb, fwd_addr;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bank_window u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic [1:0] sz, input logic [3:0] a,
                        input logic [31:0] d);
    acc_en = 1'b1; acc_wr = w; acc_size = sz; acc_addr = a; acc_wdata = d;
    @(posedge clk); @(negedge clk);
    acc_en = 1'b0;
  endtask

  task automatic do_wr(input logic [1:0] sz, input logic [3:0] a, input logic [31:0] d);
    access(1'b1, sz, a, d);
  endtask

  task automatic do_rd(input logic [1:0] sz, input logic [3:0] a, output logic [31:0] v);
    access(1'b0, sz, a, 32'd0);
    v = rd_data;
  endtask

  task automatic sel(input logic [7:0] b);
    do_wr(2'd0, 4'd14, {24'd0, b});
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk("R1 cfg", cfg, 32'hA0B1);
    chk("R1 ctl", ctl, 32'h1210);
    chk("R1 ercv", ercv, 32'h1F);
    chk("R1 tx", tx_ctrl, 0);
    chk("R1 rx", rx_ctrl, 0);
    chk("R1 ptr", ptr, 0);
    chk("R1 gp", gp, 0);
    chk("R1 soft_rst", soft_rst, 0);
    do_rd(2'd0, 4'd14, v);
    chk("R1 bank", v, 0);
  endtask

  task automatic t_bank_sel;
    logic [31:0] v;
    for (int b = 0; b < 4; b++) begin
      sel(8'(b));
      do_rd(2'd0, 4'd14, v);
      chk("R2 bank readback", v, 32'(b));
      do_wr(2'd0, 4'd15, 32'hFF);
      do_rd(2'd0, 4'd15, v);
      chk("R2 offset15", v, 32'h33);
      do_rd(2'd0, 4'd14, v);
      chk("R2 bank after 15 write", v, 32'(b));
    end
  endtask

  task automatic t_bank0;
    logic [31:0] v;
    sel(8'd0);
    do_wr(2'd1, 4'd0, 32'h2345);
    chk("R3 tx", tx_ctrl, 32'h2345);
    do_wr(2'd1, 4'd4, 32'h0123);
    chk("R3 rx", rx_ctrl, 32'h0123);
    do_rd(2'd0, 4'd3, v);
    chk("R3 off3", v, 32'h40);
    do_rd(2'd1, 4'd8, v);
    chk("R3 pages", v, 32'h0204);
    do_rd(2'd1, 4'd4, v);
    chk("R3 rx read", v, 32'h0123);
  endtask

  task automatic t_bank1;
    logic [31:0] v;
    sel(8'd1);
    do_wr(2'd1, 4'd0, 32'h1357);
    chk("R4 cfg", cfg, 32'h1357);
    do_wr(2'd1, 4'd10, 32'hBEEF);
    chk("R4 gp", gp, 32'hBEEF);
    do_wr(2'd0, 4'd12, 32'hFF);
    chk("R4 ctl low clear", ctl, 32'h12FC);
    do_wr(2'd0, 4'd13, 32'h08);
    do_rd(2'd1, 4'd12, v);
    chk("R4 ctl read", v, 32'h08FC);
  endtask

  task automatic t_bank3;
    logic [31:0] v;
    sel(8'd3);
    do_wr(2'd0, 4'd12, 32'hFF);
    chk("R5 ercv full", ercv, 32'h1F);
    do_wr(2'd0, 4'd12, 32'hE5);
    do_rd(2'd0, 4'd12, v);
    chk("R5 ercv masked", v, 32'h05);
    do_rd(2'd2, 4'd8, v);
    chk("R5 constants", v, 32'h33913330);
  endtask

  task automatic t_bank2;
    logic [31:0] v;
    sel(8'd2);
    do_wr(2'd1, 4'd6, 32'hFFFF);
    chk("R11 ptr", ptr, 32'hFFFF);
    chk("R11 ptr not forwarded", fwd_strb, 0);
    do_rd(2'd2, 4'd4, v);
    chk("R11 status+ptr", v, 32'hF7FF2211);
    do_rd(2'd1, 4'd2, v);
    chk("R11 pkt/alloc", v, 32'h8003);
    do_rd(2'd1, 4'd12, v);
    chk("R11 irq", v, 32'h5544);
    do_wr(2'd1, 4'd12, 32'hA55A);
    chk("R11 fwd strb", fwd_strb, 32'h3);
    chk("R11 fwd addr", fwd_addr, 32'hC);
    chk("R11 fwd data", fwd_data[15:0], 32'hA55A);
  endtask

  task automatic t_split;
    logic [31:0] v;
    sel(8'd0);
    do_wr(2'd2, 4'd1, 32'hDEAD6789);
    chk("R7 word write aligned", tx_ctrl, 32'h6789);
    do_rd(2'd2, 4'd3, v);
    chk("R7 word read", v, 32'h40006789);
    do_rd(2'd0, 4'd1, v);
    chk("R7 byte read", v, 32'h67);
  endtask

  task automatic t_word_c;
    logic [31:0] v;
    sel(8'd1);
    do_wr(2'd2, 4'd12, 32'h0003ABCD);
    chk("R8 ctl untouched", ctl, 32'h08FC);
    do_rd(2'd0, 4'd14, v);
    chk("R8 bank written", v, 32'h3);
  endtask

  task automatic t_unimpl;
    logic [31:0] v;
    sel(8'd1);
    do_wr(2'd1, 4'd4, 32'hFFFF);
    do_rd(2'd1, 4'd4, v);
    chk("R10 bank1 IA read", v, 0);
    chk("R10 cfg unchanged", cfg, 32'h1357);
    sel(8'd0);
    do_wr(2'd1, 4'd12, 32'hFFFF);
    do_rd(2'd1, 4'd12, v);
    chk("R10 bank0 off12", v, 0);
    chk("R10 tx unchanged", tx_ctrl, 32'h6789);
  endtask

  task automatic t_latency;
    logic [31:0] v;
    do_rd(2'd0, 4'd0, v);
    chk("R9 rd_valid after read", rd_valid, 1);
    @(posedge clk); @(negedge clk);
    chk("R9 rd_valid idle", rd_valid, 0);
    do_wr(2'd0, 4'd15, 32'h0);
    chk("R9 rd_valid after write", rd_valid, 0);
  endtask

  task automatic t_softrst;
    logic [31:0] v;
    sel(8'd0);
    do_wr(2'd0, 4'd5, 32'h80);
    chk("R6 pulse high", soft_rst, 1);
    chk("R6 rx stored", rx_ctrl, 32'h8023);
    do_wr(2'd0, 4'd0, 32'h55);
    chk("R6 pulse one cycle", soft_rst, 0);
    chk("R6 write dropped", tx_ctrl, 0);
    chk("R6 rx reset", rx_ctrl, 0);
    chk("R6 cfg reset", cfg, 32'hA0B1);
    chk("R6 ctl reset", ctl, 32'h1210);
    chk("R6 ercv reset", ercv, 32'h1F);
    chk("R6 ptr reset", ptr, 0);
    chk("R6 gp reset", gp, 0);
    do_rd(2'd0, 4'd14, v);
    chk("R6 bank reset", v, 0);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_bank_sel();
    t_bank0();
    t_bank1();
    t_bank3();
    t_bank2();
    t_split();
    t_word_c();
    t_unimpl();
    t_latency();
    t_softrst();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule